// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the general register file of a processor core that keeps separate copies of some registers per processor mode. An instruction names a register with a 4-bit index, from r0 to r15. The block turns that index, together with the current processor mode, into one of 31 physical storage words. Exception handlers therefore get their own stack pointer and link register, and fast-interrupt code gets its own r8 to r14, with no save or restore by software. Banked words are fixed storage. Entering or leaving a mode never creates, clears or copies them.

The instruction side has two combinational read ports and one write port. The write commits at the rising clock edge. A third, explicit access port names a mode as well as an index. Context-switch code uses it to read or overwrite another mode's copy while the core stays in its current mode. Tasks that run in the same mode share one physical set. Task switching is left to software.

Mode encoding on `mode` and `xMode`:
- 0: user
- 1: system
- 2: supervisor
- 3: abort
- 4: undefined
- 5: IRQ
- 6: FIQ
- 7: not recognised, and treated as user

Top module: `bankedRegFile`

## Requirements
- R1: After reset, every physical register reads zero through the instruction read ports and through the explicit port, in every mode.
- R2: Indices r0 to r7 and r15 select one shared physical register in every mode, so a write in any mode is seen by reads in any other mode.
- R3: User (0), system (1) and the unrecognised code 7 all select the same physical registers for every index.
- R4: Supervisor (2), abort (3), undefined (4) and IRQ (5) each have a private r13 and r14. In these modes r8 to r12 select the user copies.
- R5: FIQ (6) has private copies of r8 to r14. These are separate from the user copies and from every other mode's copies.
- R6: A banked copy keeps its value across any number of mode changes, until that copy itself is written.
- R7: Reads are combinational. A write on the instruction port takes effect at the rising clock edge, so a read of the same register in the same cycle returns the old value.
- R8: The two instruction read ports decode their indices independently and can read different registers in the same cycle.
- R9: The explicit port returns the register that `xIdx` selects under `xMode`, whatever the current `mode` is.
- R10: An explicit write changes only the register that `xIdx` selects under `xMode`. The registers that the current mode selects for other physical words stay unchanged.
- R11: When the instruction write port and the explicit write port hit the same physical register in one cycle, the explicit write wins. When they hit different registers, both writes land.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low; clears all 31 words |
| mode | input | 3 | Current processor mode |
| rdIdxA | input | 4 | Read port A register index |
| rdDataA | output | DATA_W | Read port A data |
| rdIdxB | input | 4 | Read port B register index |
| rdDataB | output | DATA_W | Read port B data |
| wrEn | input | 1 | Instruction write enable |
| wrIdx | input | 4 | Instruction write index, interpreted under `mode` |
| wrData | input | DATA_W | Instruction write data |
| xMode | input | 3 | Mode named by the explicit access port |
| xIdx | input | 4 | Register index for the explicit access port |
| xWrEn | input | 1 | Explicit port write enable |
| xWrData | input | DATA_W | Explicit port write data |
| xRdData | output | DATA_W | Explicit port read data |

## Verification
The assertions assume that `mode`, the indices, the write enables and the data inputs are stable around each rising edge, and that they hold known values whenever reset is released. The priority and hold properties also assume that the two write enables are never unknown. The bench changes every input only on the falling edge and drives every input to a defined value from time zero, so these assumptions always hold. It uses all eight mode codes, including the unrecognised one.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

  localparam int ARCH_REGS = 16;
  localparam int IDX_W     = 4;
  localparam int MODE_W    = 3;
  localparam int FIQ_BANKED = 7;                              // r8..r14
  localparam int PAIR_MODES = 4;                              // svc, abt, und, irq
  localparam int NUM_PHYS  = ARCH_REGS + FIQ_BANKED + 2 * PAIR_MODES;
  localparam int PHYS_W    = $clog2(NUM_PHYS);
  localparam int FIQ_BASE  = ARCH_REGS;
  localparam int PAIR_BASE = FIQ_BASE + FIQ_BANKED;

  typedef logic [PHYS_W-1:0] physIdx_t;
  typedef logic [IDX_W-1:0]  archIdx_t;

  typedef enum logic [MODE_W-1:0] {
    MODE_USER   = 3'd0,
    MODE_SYSTEM = 3'd1,
    MODE_SUPER  = 3'd2,
    MODE_ABORT  = 3'd3,
    MODE_UNDEF  = 3'd4,
    MODE_IRQ    = 3'd5,
    MODE_FIQ    = 3'd6,
    MODE_RSVD   = 3'd7
  } cpuMode_e;

  // Strobes and addresses handed from the bank decoder to the storage.
  typedef struct packed {
    physIdx_t rdAddrA;
    physIdx_t rdAddrB;
    physIdx_t xAddr;
    physIdx_t wrAddr;
    logic     wrValid;
    logic     xWrValid;
  } bankCtl_t;

  // Slot of a two-register bank (r13/r14) for a mode, counted from PAIR_BASE.
  function automatic int pairSlot(cpuMode_e m);
    case (m)
      MODE_SUPER: return 0;
      MODE_ABORT: return 1;
      MODE_UNDEF: return 2;
      MODE_IRQ:   return 3;
      default:    return -1;
    endcase
  endfunction

  function automatic physIdx_t mapPhys(cpuMode_e m, archIdx_t idx);
    physIdx_t res;
    int       slot;
    res  = PHYS_W'(idx);
    slot = pairSlot(m);
    if (idx >= 4'd8 && idx <= 4'd14) begin
      if (m == MODE_FIQ) begin
        res = PHYS_W'(FIQ_BASE) + PHYS_W'(idx - 4'd8);
      end else if (idx >= 4'd13 && slot >= 0) begin
        res = PHYS_W'(PAIR_BASE + 2 * slot) + PHYS_W'(idx - 4'd13);
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/bankDecode.sv
module bankDecode
  import bankreg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [MODE_W-1:0]     mode,
  input  logic [IDX_W-1:0]      rdIdxA,
  input  logic [IDX_W-1:0]      rdIdxB,
  input  logic                  wrEn,
  input  logic [IDX_W-1:0]      wrIdx,
  input  logic [MODE_W-1:0]     xMode,
  input  logic [IDX_W-1:0]      xIdx,
  input  logic                  xWrEn,
  output bankCtl_t              ctl
);

  localparam int NUM_MAP = 4;   // rd A, rd B, write, explicit

  cpuMode_e  curMode;
  cpuMode_e  extMode;
  archIdx_t  mapIdx  [NUM_MAP];
  cpuMode_e  mapMode [NUM_MAP];
  physIdx_t  mapOut  [NUM_MAP];

  assign curMode = cpuMode_e'(mode);
  assign extMode = cpuMode_e'(xMode);

  always_comb begin
    mapIdx[0]  = rdIdxA;  mapMode[0] = curMode;
    mapIdx[1]  = rdIdxB;  mapMode[1] = curMode;
    mapIdx[2]  = wrIdx;   mapMode[2] = curMode;
    mapIdx[3]  = xIdx;    mapMode[3] = extMode;
  end

  for (genvar p = 0; p < NUM_MAP; p++) begin : g_map
    assign mapOut[p] = mapPhys(mapMode[p], mapIdx[p]);
  end

  always_comb begin
    ctl.rdAddrA  = mapOut[0];
    ctl.rdAddrB  = mapOut[1];
    ctl.wrAddr   = mapOut[2];
    ctl.xAddr    = mapOut[3];
    ctl.wrValid  = wrEn;
    ctl.xWrValid = xWrEn;
  end

  // R2: low indices and r15 never leave the shared set
  p_low_shared_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdxA < 4'd8 || rdIdxA == 4'd15) |-> ctl.rdAddrA == PHYS_W'(rdIdxA));

  // R3: user-like modes stay inside the sixteen shared words
  p_userlike_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_USER || mode == MODE_SYSTEM || mode == MODE_RSVD)
      |-> (ctl.rdAddrB < PHYS_W'(ARCH_REGS)));

  // R4: paired-bank modes share r8..r12 with user
  p_pair_share_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode >= MODE_SUPER && mode <= MODE_IRQ && wrIdx >= 4'd8 && wrIdx <= 4'd12)
      |-> ctl.wrAddr == PHYS_W'(wrIdx));

  // R5: FIQ high registers land in the FIQ block
  p_fiq_bank_r5: assert property (@(posedge clk) disable iff (!rstN)
    (xMode == MODE_FIQ && xIdx >= 4'd8 && xIdx <= 4'd14)
      |-> (ctl.xAddr >= PHYS_W'(FIQ_BASE) && ctl.xAddr < PHYS_W'(PAIR_BASE)));

  // R9: every mapped address exists
  p_addr_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.xAddr < PHYS_W'(NUM_PHYS) && ctl.rdAddrA < PHYS_W'(NUM_PHYS));

endmodule

// File: rtl/bankStore.sv
module bankStore
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  bankCtl_t          ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] xWrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] xRdData
);

  logic [DATA_W-1:0] regs [NUM_PHYS];

  for (genvar i = 0; i < NUM_PHYS; i++) begin : g_word
    logic hitIns;
    logic hitExt;
    assign hitIns = ctl.wrValid  && (ctl.wrAddr == PHYS_W'(i));
    assign hitExt = ctl.xWrValid && (ctl.xAddr  == PHYS_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regs[i] <= '0;
      end else if (hitExt) begin
        regs[i] <= xWrData;       // explicit port has priority
      end else if (hitIns) begin
        regs[i] <= wrData;
      end
    end

    // R6: an untouched word keeps its value
    p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      (!(ctl.wrValid && ctl.wrAddr == PHYS_W'(i)) &&
       !(ctl.xWrValid && ctl.xAddr == PHYS_W'(i))) |=> $stable(regs[i]));
  end

  function automatic logic [DATA_W-1:0] readWord(physIdx_t a);
    return (a < PHYS_W'(NUM_PHYS)) ? regs[a] : '0;
  endfunction

  assign rdDataA = readWord(ctl.rdAddrA);
  assign rdDataB = readWord(ctl.rdAddrB);
  assign xRdData = readWord(ctl.xAddr);

  // R7: instruction write visible after the edge unless overridden
  p_write_lands_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrValid && !(ctl.xWrValid && ctl.xAddr == ctl.wrAddr))
      |=> readWord($past(ctl.wrAddr)) == $past(wrData));

  // R10: explicit write visible after the edge
  p_xwrite_lands_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.xWrValid |=> readWord($past(ctl.xAddr)) == $past(xWrData));

  // R11: on collision the explicit data is stored
  p_collide_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrValid && ctl.xWrValid && ctl.wrAddr == ctl.xAddr)
      |=> readWord($past(ctl.wrAddr)) == $past(xWrData));

endmodule

// File: rtl/bankedRegFile.sv
module bankedRegFile
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        mode,
  input  logic [3:0]        rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdIdxB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        xMode,
  input  logic [3:0]        xIdx,
  input  logic              xWrEn,
  input  logic [DATA_W-1:0] xWrData,
  output logic [DATA_W-1:0] xRdData
);

  bankCtl_t ctl;

  bankDecode u_decode (
    .clk    (clk),
    .rstN   (rstN),
    .mode   (mode),
    .rdIdxA (rdIdxA),
    .rdIdxB (rdIdxB),
    .wrEn   (wrEn),
    .wrIdx  (wrIdx),
    .xMode  (xMode),
    .xIdx   (xIdx),
    .xWrEn  (xWrEn),
    .ctl    (ctl)
  );

  bankStore #(.DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .wrData  (wrData),
    .xWrData (xWrData),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB),
    .xRdData (xRdData)
  );

endmodule

// File: tb/bankedRegFile_test.sv
module bankedRegFile_test;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    mode = '0;
  logic [3:0]    rdIdxA = '0, rdIdxB = '0, wrIdx = '0, xIdx = '0;
  logic          wrEn = 1'b0, xWrEn = 1'b0;
  logic [DW-1:0] wrData = '0, xWrData = '0;
  logic [2:0]    xMode = '0;
  logic [DW-1:0] rdDataA, rdDataB, xRdData;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  bankedRegFile #(.DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .mode(mode),
    .rdIdxA(rdIdxA), .rdDataA(rdDataA),
    .rdIdxB(rdIdxB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .xMode(xMode), .xIdx(xIdx), .xWrEn(xWrEn),
    .xWrData(xWrData), .xRdData(xRdData)
  );

  typedef struct packed {
    logic [2:0]    md;
    logic          we;
    logic [3:0]    wi;
    logic [DW-1:0] wd;
    logic [3:0]    ra;
    logic [3:0]    rb;
    logic [DW-1:0] ea;
    logic [DW-1:0] eb;
  } vec_t;

  // Reads are checked before the edge that commits the same row's write.
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b1, 4'd0,  32'h0000_00A0, 4'd0,  4'd1,  32'h0,          32'h0},          // R7 old value
    '{3'd2, 1'b1, 4'd13, 32'h0000_5C13, 4'd0,  4'd13, 32'h0000_00A0, 32'h0},          // R2
    '{3'd2, 1'b1, 4'd14, 32'h0000_5C14, 4'd13, 4'd8,  32'h0000_5C13, 32'h0},          // R4
    '{3'd0, 1'b1, 4'd13, 32'h0000_0013, 4'd13, 4'd14, 32'h0,          32'h0},          // R4
    '{3'd6, 1'b1, 4'd8,  32'h0000_F108, 4'd0,  4'd13, 32'h0000_00A0, 32'h0},          // R5
    '{3'd6, 1'b1, 4'd13, 32'h0000_F113, 4'd8,  4'd14, 32'h0000_F108, 32'h0},          // R5
    '{3'd0, 1'b1, 4'd8,  32'h0000_0008, 4'd8,  4'd13, 32'h0,          32'h0000_0013}, // R5
    '{3'd1, 1'b0, 4'd0,  32'h0,          4'd8,  4'd13, 32'h0000_0008, 32'h0000_0013}, // R3
    '{3'd7, 1'b1, 4'd9,  32'h0000_0009, 4'd13, 4'd8,  32'h0000_0013, 32'h0000_0008}, // R3
    '{3'd5, 1'b1, 4'd13, 32'h0000_1413, 4'd8,  4'd9,  32'h0000_0008, 32'h0000_0009}, // R4
    '{3'd3, 1'b1, 4'd15, 32'h0000_00F0, 4'd13, 4'd14, 32'h0,          32'h0},          // R4
    '{3'd4, 1'b1, 4'd14, 32'h0000_0D14, 4'd15, 4'd13, 32'h0000_00F0, 32'h0},          // R2
    '{3'd2, 1'b0, 4'd0,  32'h0,          4'd13, 4'd14, 32'h0000_5C13, 32'h0000_5C14}, // R6
    '{3'd5, 1'b0, 4'd0,  32'h0,          4'd13, 4'd15, 32'h0000_1413, 32'h0000_00F0}, // R6
    '{3'd4, 1'b0, 4'd0,  32'h0,          4'd14, 4'd9,  32'h0000_0D14, 32'h0000_0009}, // R6
    '{3'd6, 1'b0, 4'd0,  32'h0,          4'd8,  4'd9,  32'h0000_F108, 32'h0}           // R8
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset state through both read ports and the explicit port
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      mode = 3'(i % 8); rdIdxA = 4'(i); rdIdxB = 4'(15 - i);
      xMode = 3'd6; xIdx = 4'(i);
      #1;
      check("R1 rdA", rdDataA, '0);
      check("R1 rdB", rdDataB, '0);
      check("R1 x", xRdData, '0);
    end

    // Table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      mode = VECS[v].md; wrEn = VECS[v].we; wrIdx = VECS[v].wi; wrData = VECS[v].wd;
      rdIdxA = VECS[v].ra; rdIdxB = VECS[v].rb;
      #1;
      check($sformatf("R2-table row %0d port A (R8)", v), rdDataA, VECS[v].ea);
      check($sformatf("R3-table row %0d port B (R8)", v), rdDataB, VECS[v].eb);
    end
    @(negedge clk); wrEn = 1'b0;

    // R9: explicit reads of other modes from user mode
    mode = 3'd0;
    xMode = 3'd2; xIdx = 4'd13; #1; check("R9 svc r13", xRdData, 32'h0000_5C13);
    xMode = 3'd6; xIdx = 4'd8;  #1; check("R9 fiq r8",  xRdData, 32'h0000_F108);
    xMode = 3'd0; xIdx = 4'd13; #1; check("R9 usr r13", xRdData, 32'h0000_0013);
    xMode = 3'd7; xIdx = 4'd9;  #1; check("R9 rsvd r9", xRdData, 32'h0000_0009);

    // R10: explicit write to IRQ r14 while in user mode
    @(negedge clk);
    xMode = 3'd5; xIdx = 4'd14; xWrEn = 1'b1; xWrData = 32'h0000_1414;
    rdIdxA = 4'd14;
    @(negedge clk); xWrEn = 1'b0;
    #1;
    check("R10 user r14 untouched", rdDataA, 32'h0);
    check("R10 irq r14 via x", xRdData, 32'h0000_1414);
    mode = 3'd5; #1;
    check("R10 irq r14 in mode", rdDataA, 32'h0000_1414);

    // R11: collision on supervisor r13
    @(negedge clk);
    mode = 3'd2; wrEn = 1'b1; wrIdx = 4'd13; wrData = 32'h1111_1111;
    xWrEn = 1'b1; xMode = 3'd2; xIdx = 4'd13; xWrData = 32'h2222_2222;
    rdIdxA = 4'd13;
    @(negedge clk); wrEn = 1'b0; xWrEn = 1'b0; #1;
    check("R11 collision", rdDataA, 32'h2222_2222);

    // R11: different targets, both land
    @(negedge clk);
    mode = 3'd0; wrEn = 1'b1; wrIdx = 4'd13; wrData = 32'h3333_3333;
    xWrEn = 1'b1; xMode = 3'd2; xIdx = 4'd13; xWrData = 32'h4444_4444;
    @(negedge clk); wrEn = 1'b0; xWrEn = 1'b0; #1;
    check("R11 user write", rdDataA, 32'h3333_3333);
    check("R11 x write", xRdData, 32'h4444_4444);

    // R7: same-cycle read gives old value, then new
    @(negedge clk);
    mode = 3'd1; wrEn = 1'b1; wrIdx = 4'd1; wrData = 32'h0000_0077;
    rdIdxA = 4'd1; #1;
    check("R7 before edge", rdDataA, 32'h0);
    @(negedge clk); wrEn = 1'b0; #1;
    check("R7 after edge", rdDataA, 32'h0000_0077);

    // R1: reset again clears banked copies
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    mode = 3'd2; rdIdxA = 4'd13; rdIdxB = 4'd1; xMode = 3'd6; xIdx = 4'd8; #1;
    check("R1 svc r13 after reset", rdDataA, 32'h0);
    check("R1 r1 after reset", rdDataB, 32'h0);
    check("R1 fiq r8 after reset", xRdData, 32'h0);

    @(negedge clk);
    finishRun();
  end

endmodule